// File: doc/BRIEF.md
# Comparator Event Timer

A free-running 64-bit up-counter with a small set of comparator channels, all reached through a single-cycle 32-bit register port. Software stops the counter through the general configuration word, loads both counter halves and starts it again. Each channel watches the counter and raises a one-clock interrupt pulse when the counter reaches the channel's match value. A channel runs either in one-shot mode, where it fires once per match value, or in periodic mode, where each match advances the match value by a stored period.

Periodic channels are loaded through an armed sequence. A configuration write that sets the value-set bit arms the channel. The first comparator write after that sets the first match and the second sets the period. Any channel can also run in a 32-bit mode that ignores the upper counter half. Each channel's pulse normally goes to one of eight interrupt lines, chosen by its route field. When legacy routing is on, channel 0 is moved to a dedicated system-tick line and channel 1 to a dedicated real-time-clock line.

Top module: `event_timer`

## Requirements
- R1: Reading byte address 0x000 returns a capability word whose bits [12:8] equal the channel count minus one and whose bit 15 is 1 (legacy routing supported). Address 0x004 returns the tick period in femtoseconds. Every unmapped address reads 0, and `bus_rdata` is 0 whenever `bus_sel` is low.
- R2: The general configuration word at 0x010 holds enable in bit 0 and legacy routing in bit 1, both 0 after reset and both readable.
- R3: The counter reads as its low word at 0x0F0 and its high word at 0x0F4. It rises by one on each clock while enable is set and holds while enable is clear. A write to either word replaces that word, taking priority over the increment, and a read returns the live value.
- R4: Channel n sits at 0x100 + 0x20·n, with configuration at +0x0, comparator low at +0x8 and comparator high at +0xC. The configuration bits are: 2 interrupt enable, 3 periodic, 6 value-set, 8 32-bit mode, [11:9] route. All of these read back except value-set.
- R5: One-shot mode. A comparator write sets the match value, and the comparator reads back exactly that value. When the running counter equals it, the channel pulses for exactly one clock, starting at the clock edge after the counter holds the match value. No further pulse follows.
- R6: A configuration write with value-set and periodic both 1 arms the channel. The next comparator-low write sets the match value and the one after sets the period. A comparator-high write goes to the period once the match value is loaded, and to the match value otherwise.
- R7: Periodic mode. Each match adds the stored period to the comparator and produces a one-clock pulse. The comparator reads back the advanced value.
- R8: In 32-bit mode, matching uses only counter bits [31:0]. Periodic advance wraps modulo 2^32, comparator high reads 0, and writes to comparator high are ignored.
- R9: Without legacy routing, a channel's pulse appears on `irq_line[route]`. A channel with interrupt enable clear produces no pulse.
- R10: With legacy routing on, channel 0 pulses `irq_tick` and channel 1 pulses `irq_rtc`, and neither appears on `irq_line`. Other channels still use their route. With legacy routing off, `irq_tick` and `irq_rtc` stay low.
- R11: The value-set bit always reads as 0 and leaves the armed state once the period write completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 9 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle |
| irq_line | output | 8 | Routed channel interrupt pulses |
| irq_tick | output | 1 | Legacy system-tick pulse (channel 0) |
| irq_rtc | output | 1 | Legacy real-time-clock pulse (channel 1) |

## Verification
A wrong arm state shows up at the next comparator read. The match value or the period ends up in the wrong register, so the comparator reads back the period, and the pulse train falls on a different cycle within one period. A stuck or mis-carried counter appears in the first counter read after enable, and as a pulse that arrives early, late or not at all. Every pulse is therefore compared against the exact clock in which the requirements place it. A routing error appears as the correct pulse time on the wrong line, in the very cycle the pulse is due.

// File: rtl/et_pkg.sv
package et_pkg;
    localparam int WORD_W    = 32;
    localparam int CNT_W     = 64;
    localparam int ADDR_W    = 9;
    localparam int ROUTE_W   = 3;
    localparam int NUM_LINES = 1 << ROUTE_W;
    localparam int CH_IDX_W  = ADDR_W - 6;

    localparam logic [ADDR_W-1:0] A_CAP    = 9'h000;
    localparam logic [ADDR_W-1:0] A_PERIOD = 9'h004;
    localparam logic [ADDR_W-1:0] A_GCFG   = 9'h010;
    localparam logic [ADDR_W-1:0] A_CNT_LO = 9'h0F0;
    localparam logic [ADDR_W-1:0] A_CNT_HI = 9'h0F4;

    localparam logic [4:0] O_CFG    = 5'h00;
    localparam logic [4:0] O_CMP_LO = 5'h08;
    localparam logic [4:0] O_CMP_HI = 5'h0C;

    localparam int B_IRQ_EN   = 2;
    localparam int B_PERIODIC = 3;
    localparam int B_VALSET   = 6;
    localparam int B_MODE32   = 8;
    localparam int B_ROUTE    = 9;

    localparam int G_EN  = 0;
    localparam int G_LEG = 1;

    localparam int CAP_REV  = 0;
    localparam int CAP_NCH  = 8;
    localparam int CAP_WIDE = 13;
    localparam int CAP_LEG  = 15;

    typedef struct packed {
        logic [ROUTE_W-1:0] route;
        logic               mode32;
        logic               periodic;
        logic               irq_en;
    } ch_cfg_t;

    typedef enum logic [1:0] {
        ARM_IDLE,
        ARM_MATCH,
        ARM_PERIOD
    } arm_t;

    function automatic logic [WORD_W-1:0] cfg_to_word(ch_cfg_t c);
        logic [WORD_W-1:0] w;
        w = '0;
        w[B_IRQ_EN]            = c.irq_en;
        w[B_PERIODIC]          = c.periodic;
        w[B_MODE32]            = c.mode32;
        w[B_ROUTE +: ROUTE_W]  = c.route;
        return w;
    endfunction

    function automatic ch_cfg_t word_to_cfg(logic [WORD_W-1:0] w);
        ch_cfg_t c;
        c.irq_en   = w[B_IRQ_EN];
        c.periodic = w[B_PERIODIC];
        c.mode32   = w[B_MODE32];
        c.route    = w[B_ROUTE +: ROUTE_W];
        return c;
    endfunction

    function automatic logic cmp_hit(logic [CNT_W-1:0] cnt, logic [CNT_W-1:0] cmp, logic m32);
        if (m32)
            return cnt[WORD_W-1:0] == cmp[WORD_W-1:0];
        return cnt == cmp;
    endfunction

    function automatic logic [CNT_W-1:0] next_match(logic [CNT_W-1:0] cmp, logic [CNT_W-1:0] per, logic m32);
        logic [CNT_W-1:0] s;
        s = cmp + per;
        if (m32)
            s[CNT_W-1:WORD_W] = '0;
        return s;
    endfunction
endpackage

// File: rtl/et_counter.sv
module et_counter
    import et_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [WORD_W-1:0] wdata,
    output logic [CNT_W-1:0]  count
);
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = run ? cnt_q + 1'b1 : cnt_q;
        if (wr_lo) cnt_d[WORD_W-1:0]     = wdata;
        if (wr_hi) cnt_d[CNT_W-1:WORD_W] = wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign count = cnt_q;
endmodule

// File: rtl/et_channel.sv
module et_channel
    import et_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [CNT_W-1:0]  count,
    input  logic              run,
    input  logic              cfg_we,
    input  logic              lo_we,
    input  logic              hi_we,
    input  logic [WORD_W-1:0] wdata,
    output ch_cfg_t           cfg_o,
    output logic [CNT_W-1:0]  cmp_o,
    output logic              fire_o
);
    ch_cfg_t          cfg_q, cfg_d;
    arm_t             arm_q, arm_d;
    logic [CNT_W-1:0] cmp_q, cmp_d;
    logic [CNT_W-1:0] per_q, per_d;
    logic             fire_q;
    logic             hit;

    assign hit = run && cmp_hit(count, cmp_q, cfg_q.mode32);

    always_comb begin
        cfg_d = cfg_q;
        arm_d = arm_q;
        cmp_d = cmp_q;
        per_d = per_q;
        if (hit && cfg_q.periodic)
            cmp_d = next_match(cmp_q, per_q, cfg_q.mode32);
        if (cfg_we) begin
            cfg_d = word_to_cfg(wdata);
            arm_d = (wdata[B_VALSET] && wdata[B_PERIODIC]) ? ARM_MATCH : ARM_IDLE;
        end
        if (lo_we) begin
            unique case (arm_q)
                ARM_MATCH: begin
                    cmp_d[WORD_W-1:0] = wdata;
                    arm_d             = ARM_PERIOD;
                end
                ARM_PERIOD: begin
                    per_d[WORD_W-1:0] = wdata;
                    arm_d             = ARM_IDLE;
                end
                default: cmp_d[WORD_W-1:0] = wdata;
            endcase
        end
        if (hi_we && !cfg_q.mode32) begin
            if (arm_q == ARM_PERIOD) per_d[CNT_W-1:WORD_W] = wdata;
            else                     cmp_d[CNT_W-1:WORD_W] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            arm_q  <= ARM_IDLE;
            cmp_q  <= '0;
            per_q  <= '0;
            fire_q <= 1'b0;
        end else begin
            cfg_q  <= cfg_d;
            arm_q  <= arm_d;
            cmp_q  <= cmp_d;
            per_q  <= per_d;
            fire_q <= hit && cfg_q.irq_en;
        end
    end

    assign cfg_o  = cfg_q;
    assign cmp_o  = cfg_q.mode32 ? {{(CNT_W-WORD_W){1'b0}}, cmp_q[WORD_W-1:0]} : cmp_q;
    assign fire_o = fire_q;
endmodule

// File: rtl/et_irq_route.sv
module et_irq_route
    import et_pkg::*;
#(
    parameter int NUM_CH = 3
) (
    input  logic [NUM_CH-1:0]              fire,
    input  logic [NUM_CH-1:0][ROUTE_W-1:0] route,
    input  logic                           legacy,
    output logic [NUM_LINES-1:0]           lines,
    output logic                           tick,
    output logic                           rtc
);
    always_comb begin
        lines = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (!(legacy && i < 2) && fire[i])
                lines[route[i]] = 1'b1;
        end
    end

    assign tick = legacy && fire[0];
    assign rtc  = legacy && fire[1];
endmodule

// File: rtl/event_timer.sv
module event_timer
    import et_pkg::*;
#(
    parameter int          NUM_CH    = 3,
    parameter logic [31:0] PERIOD_FS = 32'd69841279
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic [NUM_LINES-1:0] irq_line,
    output logic              irq_tick,
    output logic              irq_rtc
);
    logic                 wr, rd, ch_hit;
    logic [CH_IDX_W-1:0]  ch_idx;
    logic [4:0]           ch_off;
    logic                 gen_en, gen_leg;
    logic [CNT_W-1:0]     count;
    logic [WORD_W-1:0]    cap_word, rd_word;

    ch_cfg_t                        ch_cfg [NUM_CH];
    logic [CNT_W-1:0]               ch_cmp [NUM_CH];
    logic [NUM_CH-1:0]              ch_fire;
    logic [NUM_CH-1:0][ROUTE_W-1:0] ch_route;

    assign wr     = bus_sel && bus_we;
    assign rd     = bus_sel && !bus_we;
    assign ch_hit = bus_addr[ADDR_W-1];
    assign ch_idx = bus_addr[ADDR_W-2:5];
    assign ch_off = bus_addr[4:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            gen_en  <= 1'b0;
            gen_leg <= 1'b0;
        end else if (wr && bus_addr == A_GCFG) begin
            gen_en  <= bus_wdata[G_EN];
            gen_leg <= bus_wdata[G_LEG];
        end
    end

    et_counter u_counter (
        .clk   (clk),
        .rst   (rst),
        .run   (gen_en),
        .wr_lo (wr && bus_addr == A_CNT_LO),
        .wr_hi (wr && bus_addr == A_CNT_HI),
        .wdata (bus_wdata),
        .count (count)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic sel_ch;
        assign sel_ch = wr && ch_hit && ch_idx == CH_IDX_W'(i);

        et_channel u_channel (
            .clk    (clk),
            .rst    (rst),
            .count  (count),
            .run    (gen_en),
            .cfg_we (sel_ch && ch_off == O_CFG),
            .lo_we  (sel_ch && ch_off == O_CMP_LO),
            .hi_we  (sel_ch && ch_off == O_CMP_HI),
            .wdata  (bus_wdata),
            .cfg_o  (ch_cfg[i]),
            .cmp_o  (ch_cmp[i]),
            .fire_o (ch_fire[i])
        );

        assign ch_route[i] = ch_cfg[i].route;
    end

    et_irq_route #(.NUM_CH(NUM_CH)) u_route (
        .fire   (ch_fire),
        .route  (ch_route),
        .legacy (gen_leg),
        .lines  (irq_line),
        .tick   (irq_tick),
        .rtc    (irq_rtc)
    );

    always_comb begin
        cap_word                  = '0;
        cap_word[CAP_REV +: 8]    = 8'h01;
        cap_word[CAP_NCH +: 5]    = 5'(NUM_CH - 1);
        cap_word[CAP_WIDE]        = 1'b1;
        cap_word[CAP_LEG]         = 1'b1;
    end

    always_comb begin
        rd_word = '0;
        if (rd) begin
            if (ch_hit) begin
                for (int i = 0; i < NUM_CH; i++) begin
                    if (ch_idx == CH_IDX_W'(i)) begin
                        case (ch_off)
                            O_CFG:    rd_word = cfg_to_word(ch_cfg[i]);
                            O_CMP_LO: rd_word = ch_cmp[i][WORD_W-1:0];
                            O_CMP_HI: rd_word = ch_cmp[i][CNT_W-1:WORD_W];
                            default:  rd_word = '0;
                        endcase
                    end
                end
            end else begin
                case (bus_addr)
                    A_CAP:    rd_word = cap_word;
                    A_PERIOD: rd_word = PERIOD_FS;
                    A_GCFG:   rd_word = {{(WORD_W-2){1'b0}}, gen_leg, gen_en};
                    A_CNT_LO: rd_word = count[WORD_W-1:0];
                    A_CNT_HI: rd_word = count[CNT_W-1:WORD_W];
                    default:  rd_word = '0;
                endcase
            end
        end
    end

    assign bus_rdata = rd_word;
endmodule

// File: rtl/event_timer_chk.sv
module event_timer_chk
    import et_pkg::*;
#(
    parameter int NUM_CH = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_sel,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              wbit0,
    input logic [WORD_W-1:0] bus_rdata,
    input logic              irq_tick,
    input logic              irq_rtc,
    input logic [CNT_W-1:0]  count,
    input logic              run,
    input logic              legacy
);
    logic cnt_wr, rd_cap, rd_cfg, wr_gcfg;

    assign cnt_wr  = bus_sel && bus_we && (bus_addr == A_CNT_LO || bus_addr == A_CNT_HI);
    assign rd_cap  = bus_sel && !bus_we && bus_addr == A_CAP;
    assign rd_cfg  = bus_sel && !bus_we && bus_addr[ADDR_W-1] && bus_addr[4:0] == O_CFG;
    assign wr_gcfg = bus_sel && bus_we && bus_addr == A_GCFG;

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!run && !cnt_wr) |=> count == $past(count));                    // R3
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (run && !cnt_wr) |=> count == $past(count) + 64'd1);             // R3
    AST_IDLE_RDATA: assert property (@(posedge clk) disable iff (rst)
        !bus_sel |-> bus_rdata == '0);                                   // R1
    AST_CAP_FIELD: assert property (@(posedge clk) disable iff (rst)
        rd_cap |-> (bus_rdata[CAP_NCH +: 5] == 5'(NUM_CH - 1) && bus_rdata[CAP_LEG])); // R1
    AST_GCFG_EN: assert property (@(posedge clk) disable iff (rst)
        wr_gcfg |=> run == $past(wbit0));                                // R2
    AST_VALSET_RD: assert property (@(posedge clk) disable iff (rst)
        rd_cfg |-> !bus_rdata[B_VALSET]);                                // R11
    AST_LEGACY_OFF: assert property (@(posedge clk) disable iff (rst)
        !legacy |-> (!irq_tick && !irq_rtc));                            // R10
endmodule

bind event_timer event_timer_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .wbit0     (bus_wdata[0]),
    .bus_rdata (bus_rdata),
    .irq_tick  (irq_tick),
    .irq_rtc   (irq_rtc),
    .count     (count),
    .run       (gen_en),
    .legacy    (gen_leg)
);

// File: tb/event_timer_bench.sv
module event_timer_bench;
    localparam int          NCH = 3;
    localparam logic [31:0] PFS = 32'd69841279;

    localparam logic [8:0] CAP = 9'h000, PER = 9'h004, GCF = 9'h010;
    localparam logic [8:0] CLO = 9'h0F0, CHI = 9'h0F4;

    typedef struct {
        int unsigned at;
        logic [9:0]  vec;
        string       req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [8:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  irq_line;
    logic        irq_tick, irq_rtc;
    logic [9:0]  obs;

    int unsigned pc = 0;
    int unsigned rd_pc;
    int          nchk = 0;
    int          nerr = 0;
    logic        seen = 1'b0;
    exp_t        q[$];

    always #10 clk = ~clk;
    always @(posedge clk) pc <= pc + 1;

    event_timer #(.NUM_CH(NCH), .PERIOD_FS(PFS)) u_event_timer (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_line  (irq_line),
        .irq_tick  (irq_tick),
        .irq_rtc   (irq_rtc)
    );

    assign obs = {irq_rtc, irq_tick, irq_line};

    function automatic logic [8:0] ch_a(int n, int off);
        return 9'(32'h100 + n * 32 + off);
    endfunction

    task automatic chk(string r, logic [63:0] got, logic [63:0] exp);
        nchk++;
        if (got !== exp) begin
            nerr++;
            $display("FAIL %s: got %h expected %h", r, got, exp);
        end
    endtask

    task automatic bus_wr(logic [8:0] a, logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_rd(logic [8:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        rd_pc = pc;
        bus_sel = 1'b0;
    endtask

    task automatic expect_irq(int unsigned at, logic [9:0] v, string r);
        exp_t e;
        e.at = at; e.vec = v; e.req = r;
        q.push_back(e);
    endtask

    task automatic wait_pc(int unsigned t);
        while (pc < t) @(negedge clk);
    endtask

    task automatic zero_counter();
        bus_wr(GCF, 32'h0);
        bus_wr(CLO, 32'h0);
        bus_wr(CHI, 32'h0);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    endtask

    // Scoreboard monitor: pops expected pulses as their cycle arrives
    always @(negedge clk) begin
        if (!rst) begin
            if (obs != '0) seen = 1'b1;
            while (q.size() > 0 && q[0].at < pc) begin
                nchk++; nerr++;
                $display("FAIL %s: pulse missing at cycle %0d, got 000 expected %h", q[0].req, q[0].at, q[0].vec);
                void'(q.pop_front());
            end
            if (q.size() > 0 && q[0].at == pc) begin
                chk(q[0].req, 64'(obs), 64'(q[0].vec));
                void'(q.pop_front());
            end else if (obs != '0) begin
                nchk++; nerr++;
                $display("FAIL R9: stray pulse at cycle %0d, got %h expected 000", pc, obs);
            end
        end
    end

    initial begin
        #(20 * 150000);
        nchk++; nerr++;
        $display("FAIL R3: watchdog expired, got hang expected completion");
        summary();
    end

    initial begin
        logic [31:0] d;
        int unsigned e;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // reset state and fixed registers
        bus_rd(CAP, d);
        chk("R1", 64'(d[12:8]), 64'(NCH - 1));
        chk("R1", 64'(d[15]), 64'd1);
        bus_rd(PER, d);          chk("R1", 64'(d), 64'(PFS));
        bus_rd(9'h008, d);       chk("R1", 64'(d), 64'd0);
        bus_rd(ch_a(7, 0), d);   chk("R1", 64'(d), 64'd0);
        bus_rd(GCF, d);          chk("R2", 64'(d), 64'd0);
        bus_rd(CLO, d);          chk("R3", 64'(d), 64'd0);
        chk("R9", 64'(obs), 64'd0);

        // counter load, hold and count
        bus_wr(CLO, 32'h1234_5678);
        bus_wr(CHI, 32'h0000_0009);
        repeat (4) @(negedge clk);
        bus_rd(CLO, d);          chk("R3", 64'(d), 64'h1234_5678);
        bus_rd(CHI, d);          chk("R3", 64'(d), 64'h9);
        bus_wr(GCF, 32'h1);
        e = pc;
        bus_rd(GCF, d);          chk("R2", 64'(d), 64'd1);
        bus_rd(CLO, d);          chk("R3", 64'(d), 64'(32'h1234_5678 + (rd_pc - e)));
        bus_wr(GCF, 32'h0);
        bus_rd(CLO, d);
        repeat (3) @(negedge clk);
        begin
            logic [31:0] d2;
            bus_rd(CLO, d2);     chk("R3", 64'(d2), 64'(d));
        end

        // one-shot on channel 0, route 3
        zero_counter();
        bus_wr(ch_a(0, 0), (32'd1 << 2) | (32'd3 << 9));
        bus_wr(ch_a(0, 8), 32'd20);
        bus_wr(ch_a(0, 12), 32'd0);
        bus_rd(ch_a(0, 0), d);   chk("R4", 64'(d), 64'((32'd1 << 2) | (32'd3 << 9)));
        bus_wr(GCF, 32'h1);
        e = pc;
        expect_irq(e + 21, 10'h008, "R5");
        wait_pc(e + 45);
        chk("R5", 64'(q.size()), 64'd0);
        bus_rd(ch_a(0, 8), d);   chk("R5", 64'(d), 64'd20);
        bus_wr(GCF, 32'h0);
        bus_wr(ch_a(0, 0), 32'h0);

        // armed periodic load on channel 1, route 5
        zero_counter();
        bus_wr(ch_a(1, 0), (32'd1 << 2) | (32'd1 << 3) | (32'd1 << 6) | (32'd5 << 9));
        bus_rd(ch_a(1, 0), d);
        chk("R11", 64'(d[6]), 64'd0);
        chk("R4", 64'(d[3]), 64'd1);
        bus_wr(ch_a(1, 8), 32'd10);
        bus_wr(ch_a(1, 8), 32'd7);
        bus_rd(ch_a(1, 8), d);   chk("R6", 64'(d), 64'd10);
        bus_rd(ch_a(1, 0), d);   chk("R11", 64'(d[6]), 64'd0);
        bus_wr(GCF, 32'h1);
        e = pc;
        expect_irq(e + 11, 10'h020, "R7");
        expect_irq(e + 18, 10'h020, "R7");
        expect_irq(e + 25, 10'h020, "R7");
        wait_pc(e + 27);
        bus_wr(GCF, 32'h0);
        repeat (3) @(negedge clk);
        chk("R7", 64'(q.size()), 64'd0);
        bus_rd(ch_a(1, 8), d);   chk("R7", 64'(d), 64'd31);
        bus_wr(ch_a(1, 0), 32'h0);

        // 32-bit one-shot across the low-word wrap, channel 2 route 6
        zero_counter();
        bus_wr(ch_a(2, 0), (32'd1 << 2) | (32'd1 << 8) | (32'd6 << 9));
        bus_wr(ch_a(2, 12), 32'h77);
        bus_wr(ch_a(2, 8), 32'd4);
        bus_rd(ch_a(2, 12), d);  chk("R8", 64'(d), 64'd0);
        bus_wr(CLO, 32'hFFFF_FFF0);
        bus_wr(CHI, 32'h5);
        bus_wr(GCF, 32'h1);
        e = pc;
        expect_irq(e + 21, 10'h040, "R8");
        wait_pc(e + 30);
        bus_wr(GCF, 32'h0);
        chk("R8", 64'(q.size()), 64'd0);

        // 32-bit periodic with comparator wrap
        zero_counter();
        bus_wr(ch_a(2, 0), (32'd1 << 2) | (32'd1 << 3) | (32'd1 << 6) | (32'd1 << 8) | (32'd6 << 9));
        bus_wr(ch_a(2, 8), 32'hFFFF_FFFC);
        bus_wr(ch_a(2, 8), 32'd8);
        bus_wr(CLO, 32'hFFFF_FFF8);
        bus_wr(GCF, 32'h1);
        e = pc;
        expect_irq(e + 5, 10'h040, "R8");
        expect_irq(e + 13, 10'h040, "R8");
        wait_pc(e + 15);
        bus_wr(GCF, 32'h0);
        bus_rd(ch_a(2, 8), d);   chk("R8", 64'(d), 64'd12);
        bus_rd(ch_a(2, 12), d);  chk("R8", 64'(d), 64'd0);

        // legacy routing
        zero_counter();
        bus_wr(ch_a(0, 0), (32'd1 << 2) | (32'd2 << 9));
        bus_wr(ch_a(0, 8), 32'd5);
        bus_wr(ch_a(1, 0), (32'd1 << 2) | (32'd2 << 9));
        bus_wr(ch_a(1, 8), 32'd8);
        bus_wr(ch_a(2, 0), (32'd1 << 2) | (32'd2 << 9));
        bus_wr(ch_a(2, 12), 32'd0);
        bus_wr(ch_a(2, 8), 32'd11);
        bus_wr(GCF, 32'h3);
        e = pc;
        expect_irq(e + 6, 10'h100, "R10");
        expect_irq(e + 9, 10'h200, "R10");
        expect_irq(e + 12, 10'h004, "R10");
        wait_pc(e + 16);
        bus_wr(GCF, 32'h0);
        chk("R10", 64'(q.size()), 64'd0);

        // interrupt enable clear suppresses the pulse
        zero_counter();
        bus_wr(ch_a(0, 0), 32'd1 << 9);
        bus_wr(ch_a(0, 8), 32'd3);
        bus_wr(ch_a(1, 0), 32'h0);
        bus_wr(ch_a(2, 0), 32'h0);
        seen = 1'b0;
        bus_wr(GCF, 32'h1);
        e = pc;
        wait_pc(e + 12);
        chk("R9", 64'(seen), 64'd0);
        bus_wr(GCF, 32'h0);

        repeat (4) @(negedge clk);
        chk("R9", 64'(q.size()), 64'd0);
        summary();
    end
endmodule